// File: doc/BRIEF.md
# Smartcard UART-Mode Transmitter

This block is the sending side of a UART-mode serial channel used to talk to a smartcard. Software writes bytes through a simple write strobe. Each byte enters a four-deep queue. A shift engine takes the bytes out of the queue one at a time and sends each as a character frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. An external baud-tick enable paces the line, and every bit lasts 16 ticks.

The line settings come from four static inputs. A 2-bit length code selects the character width, and that encoding is inverted. One flag turns parity off. A second flag picks odd or even parity when parity is on. A last flag picks one or two stop bits. The shift engine captures these settings when it loads a byte, so a change to the settings in the middle of a frame only affects the next frame.

The status outputs keep two conditions apart. The first is "queue drained", meaning the last byte has moved into the shifter. The second is "line still busy", meaning the final stop bit has not ended yet. A sticky transmit-buffer-empty flag is set each time the queue drains and is cleared by a write-one pulse. The flag drives an interrupt line through an enable input.

The shift engine has five states:
- IDLE holds the line high.
- IDLE goes to START when the queue holds a byte. On that move the byte and the line settings are loaded.
- START goes to DATA after one bit time.
- DATA repeats for the configured number of bits. It then goes to PARITY if parity is on, and to STOP if it is off.
- PARITY goes to STOP after one bit time.
- STOP goes back to IDLE after one or two bit times.

Top module: `sc_uart_tx`

## Requirements
- R1: After reset, tx_line is 1, tx_empty is 1, tx_full is 0, tx_active is 0 and tbe_flag is 0.
- R2: A frame starts with one low start bit. Every bit of the frame is held for 16 baud ticks. The line is high whenever no frame is being sent.
- R3: Data bits go out least significant bit first. The count is set by char_len_code: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Unused upper bits of the written byte are not sent.
- R4: When no_parity is 1, no parity bit is sent. When no_parity is 0, one parity bit follows the data. It is odd parity when odd_parity is 1 and even parity when odd_parity is 0, and it covers only the configured data bits.
- R5: one_stop = 1 sends one high stop bit and one_stop = 0 sends two.
- R6: The queue holds up to 4 bytes and sends them in the order they were written. tx_full is 1 exactly when 4 bytes are held.
- R7: A write while tx_full is 1 is dropped. The bytes already held are sent unchanged and no extra frame appears.
- R8: tx_empty is 1 exactly when the queue holds no byte. It rises when the last held byte moves into the shifter and falls after an accepted write.
- R9: tx_active is 1 from an accepted write until the final stop bit of the last byte has ended, and 0 afterwards.
- R10: tbe_flag is set one cycle after tx_empty rises and stays set until tbe_clr is pulsed. A set in the same cycle as a clear wins. tbe_irq equals tbe_flag AND tbe_int_en.
- R11: The line settings are captured when a byte is loaded into the shifter. A change in the middle of a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Baud enable pulse; 16 pulses make one bit |
| char_len_code | input | 2 | Character length code (0=8, 1=7, 2=6, 3=5 bits) |
| no_parity | input | 1 | 1 = no parity bit |
| odd_parity | input | 1 | 1 = odd parity, 0 = even parity |
| one_stop | input | 1 | 1 = one stop bit, 0 = two stop bits |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| tbe_int_en | input | 1 | Enable for the buffer-empty interrupt |
| tbe_clr | input | 1 | Write-one pulse that clears tbe_flag |
| tx_line | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | Queue holds no byte |
| tx_full | output | 1 | Queue holds 4 bytes |
| tx_active | output | 1 | Transmission in progress |
| tbe_flag | output | 1 | Sticky buffer-empty event flag |
| tbe_irq | output | 1 | Gated buffer-empty interrupt |

## Verification
A corrupted queue pointer or count shows up as a wrong byte, a wrong order or a missing or extra frame. It also shows as tx_full or tx_empty at the wrong time, visible at the latest one frame later at tx_line. A wrong state or bit counter changes the frame length, the parity bit or the stop bits. That is caught at the first mid-bit sample that differs, at most one bit time after the fault. A bad settings capture appears as a wrong frame length when the settings change in the middle of a frame. An early fall of tx_active is caught at the last stop bit of any frame.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;

    // Length code is inverted: 0 -> 8 bits ... 3 -> 5 bits
    function automatic frame_cfg_t decode_line_cfg(
        input logic [1:0] len_code,
        input logic       no_par,
        input logic       odd_sel,
        input logic       one_stop
    );
        frame_cfg_t c;
        c.nbits    = 4'd8 - {2'b00, len_code};
        c.par_en   = ~no_par;
        c.par_odd  = odd_sel;
        c.two_stop = ~one_stop;
        return c;
    endfunction

endpackage

// File: rtl/sctx_fifo.sv
module sctx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_FULL);
    assign empty    = (count == '0);
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sctx_shifter.sv
module sctx_shifter
    import sctx_pkg::*;
#(
    parameter int CHAR_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    input  frame_cfg_t        cfg,
    output logic              pop,
    output logic              line,
    output logic              busy
);

    localparam int TICK_W = $clog2(TICKS_PER_BIT);
    localparam int BIT_W  = $clog2(CHAR_W);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);

    tx_state_e         state, state_nx;
    logic [TICK_W-1:0] tick_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [CHAR_W-1:0] shreg;
    logic [CHAR_W-1:0] char_mask;
    logic              par_bit;
    logic              stop_seen;
    frame_cfg_t        cur;
    logic              bit_end;
    logic              last_data;

    // mask of the data bits that take part in the frame
    for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
        assign char_mask[i] = (cfg.nbits > 4'(i));
    end

    assign bit_end   = baud_tick && (tick_cnt == TICK_LAST);
    assign last_data = (bit_cnt == BIT_W'(cur.nbits - 4'd1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!fifo_empty) state_nx = ST_START;
            ST_START:  if (bit_end) state_nx = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_nx = cur.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_nx = ST_STOP;
            ST_STOP:   if (bit_end && (stop_seen || !cur.two_stop)) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pop  = 1'b0;
        line = 1'b1;
        busy = 1'b1;
        unique case (state)
            ST_IDLE: begin
                pop  = !fifo_empty;
                busy = 1'b0;
            end
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_bit;
            ST_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
    end

    // datapath: load on pop, then count ticks and shift
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt  <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            stop_seen <= 1'b0;
            cur       <= '0;
        end else if (pop) begin
            tick_cnt  <= '0;
            bit_cnt   <= '0;
            shreg     <= fifo_data;
            par_bit   <= (^(fifo_data & char_mask)) ^ cfg.par_odd;
            stop_seen <= 1'b0;
            cur       <= cfg;
        end else if (busy && baud_tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            if (bit_end && state == ST_DATA) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (bit_end && state == ST_STOP) begin
                stop_seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
    import sctx_pkg::*;
#(
    parameter int FIFO_DEPTH    = 4,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [1:0] char_len_code,
    input  logic       no_parity,
    input  logic       odd_parity,
    input  logic       one_stop,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tbe_int_en,
    input  logic       tbe_clr,
    output logic       tx_line,
    output logic       tx_empty,
    output logic       tx_full,
    output logic       tx_active,
    output logic       tbe_flag,
    output logic       tbe_irq
);

    localparam int CHAR_W = 8;

    frame_cfg_t        line_cfg;
    logic [CHAR_W-1:0] fifo_data;
    logic              fifo_empty;
    logic              fifo_full;
    logic              shift_pop;
    logic              shift_busy;
    logic              empty_q;

    assign line_cfg = decode_line_cfg(char_len_code, no_parity, odd_parity, one_stop);

    sctx_fifo #(
        .WIDTH (CHAR_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (shift_pop),
        .pop_data  (fifo_data),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    sctx_shifter #(
        .CHAR_W        (CHAR_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .cfg        (line_cfg),
        .pop        (shift_pop),
        .line       (tx_line),
        .busy       (shift_busy)
    );

    // buffer-empty event: set on a rising queue-empty, write-one clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q  <= 1'b1;
            tbe_flag <= 1'b0;
        end else begin
            empty_q <= fifo_empty;
            if (fifo_empty && !empty_q) begin
                tbe_flag <= 1'b1;
            end else if (tbe_clr) begin
                tbe_flag <= 1'b0;
            end
        end
    end

    assign tx_empty  = fifo_empty;
    assign tx_full   = fifo_full;
    assign tx_active = shift_busy || !fifo_empty;
    assign tbe_irq   = tbe_flag && tbe_int_en;

endmodule

// File: rtl/sc_uart_tx_chk.sv
module sc_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic shift_pop,
    input logic tx_line,
    input logic tx_empty,
    input logic tx_full,
    input logic tx_active,
    input logic tbe_flag
);

    // R6
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    // R7
    drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && wr_en && !shift_pop) |=> tx_full);

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_line);

    // R8
    empty_rise_on_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(shift_pop));

    // R10
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbe_flag) |-> $past(tx_empty));

    // R9
    full_implies_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> tx_active);

endmodule

bind sc_uart_tx sc_uart_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .shift_pop (shift_pop),
    .tx_line   (tx_line),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full),
    .tx_active (tx_active),
    .tbe_flag  (tbe_flag)
);

// File: tb/sc_uart_tx_test.sv
module sc_uart_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;  // 16 ticks, one tick every 2 clocks

    logic       clk, rst_n, baud_tick;
    logic [1:0] char_len_code;
    logic       no_parity, odd_parity, one_stop;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       tbe_int_en, tbe_clr;
    logic       tx_line, tx_empty, tx_full, tx_active, tbe_flag, tbe_irq;

    typedef struct {
        logic [7:0] data;
        int         nbits;
        bit         par_en;
        bit         odd;
        int         stops;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    sc_uart_tx uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .baud_tick     (baud_tick),
        .char_len_code (char_len_code),
        .no_parity     (no_parity),
        .odd_parity    (odd_parity),
        .one_stop      (one_stop),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .tbe_int_en    (tbe_int_en),
        .tbe_clr       (tbe_clr),
        .tx_line       (tx_line),
        .tx_empty      (tx_empty),
        .tx_full       (tx_full),
        .tx_active     (tx_active),
        .tbe_flag      (tbe_flag),
        .tbe_irq       (tbe_irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    initial baud_tick = 1'b0;
    always @(posedge clk) baud_tick <= ~baud_tick;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic nopar, input logic odd, input logic one);
        @(negedge clk);
        char_len_code = len;
        no_parity     = nopar;
        odd_parity    = odd;
        one_stop      = one;
    endtask

    // driver: writes a byte and queues the frame it should produce
    task automatic send(input logic [7:0] d, input bit kept);
        exp_t e;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (kept) begin
            e.data   = d;
            e.nbits  = 8 - int'(char_len_code);
            e.par_en = !no_parity;
            e.odd    = odd_parity;
            e.stops  = one_stop ? 1 : 2;
            sb.push_back(e);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (tx_active !== 1'b0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(input int bits, input string tag);
        int t = 0;
        while (tx_line !== 1'b0) @(negedge clk);
        while (tx_active === 1'b1) begin
            @(negedge clk);
            t++;
        end
        chk((t >= bits * BIT_CLKS - 4) && (t <= bits * BIT_CLKS + 4), tag, 32'(t), 32'(bits * BIT_CLKS));
    endtask

    // monitor: decodes one frame from mid-bit samples and compares
    task automatic mon_frame();
        exp_t       e;
        logic [7:0] got;
        logic [7:0] m;
        logic       pb;
        if (sb.size() == 0) begin
            chk(1'b0, "R7 frame with no queued byte", 32'(0), 32'(1));
            while (tx_line !== 1'b1) @(negedge clk);
            return;
        end
        e   = sb.pop_front();
        got = '0;
        m   = '0;
        repeat (BIT_CLKS / 2) @(negedge clk);
        chk(tx_line == 1'b0, "R2 start bit low", 32'(tx_line), 32'(0));
        for (int i = 0; i < e.nbits; i++) begin
            repeat (BIT_CLKS) @(negedge clk);
            got[i] = tx_line;
            m[i]   = 1'b1;
        end
        chk(got == (e.data & m), "R3 data bits LSB first", 32'(got), 32'(e.data & m));
        if (e.par_en) begin
            repeat (BIT_CLKS) @(negedge clk);
            pb = (^(e.data & m)) ^ e.odd;
            chk(tx_line == pb, "R4 parity bit", 32'(tx_line), 32'(pb));
        end
        for (int s = 0; s < e.stops; s++) begin
            repeat (BIT_CLKS) @(negedge clk);
            chk(tx_line == 1'b1, "R5 stop bit high", 32'(tx_line), 32'(1));
        end
        chk(tx_active == 1'b1, "R9 active through final stop bit", 32'(tx_active), 32'(1));
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && tx_line === 1'b0) mon_frame();
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog actual=busy expected=idle");
            finish_run();
        end
    end

    initial begin
        int t;
        rst_n         = 1'b0;
        char_len_code = 2'd0;
        no_parity     = 1'b0;
        odd_parity    = 1'b0;
        one_stop      = 1'b0;
        wr_en         = 1'b0;
        wr_data       = '0;
        tbe_int_en    = 1'b0;
        tbe_clr       = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tx_line == 1'b1, "R1 line after reset", 32'(tx_line), 32'(1));
        chk(tx_empty == 1'b1, "R1 empty after reset", 32'(tx_empty), 32'(1));
        chk(tx_full == 1'b0, "R1 full after reset", 32'(tx_full), 32'(0));
        chk(tx_active == 1'b0, "R1 active after reset", 32'(tx_active), 32'(0));
        chk(tbe_flag == 1'b0, "R1 flag after reset", 32'(tbe_flag), 32'(0));

        // 8 bits, even parity, two stops: 1+8+1+2 = 12 bits
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
        send(8'hA5, 1);
        measure(12, "R5 R2 eight-bit even two-stop frame length");
        repeat (2) @(negedge clk);
        chk(tx_empty == 1'b1, "R8 empty after drain", 32'(tx_empty), 32'(1));
        chk(tbe_flag == 1'b1, "R10 flag set after drain", 32'(tbe_flag), 32'(1));
        chk(tbe_irq == 1'b0, "R10 irq masked", 32'(tbe_irq), 32'(0));
        tbe_int_en = 1'b1;
        @(negedge clk);
        chk(tbe_irq == 1'b1, "R10 irq enabled", 32'(tbe_irq), 32'(1));
        tbe_clr = 1'b1;
        @(negedge clk);
        tbe_clr = 1'b0;
        chk(tbe_flag == 1'b0, "R10 flag cleared by write-one", 32'(tbe_flag), 32'(0));
        chk(tbe_irq == 1'b0, "R10 irq low after clear", 32'(tbe_irq), 32'(0));
        tbe_int_en = 1'b0;

        // fill the queue with 7-bit odd one-stop frames
        set_cfg(2'd1, 1'b0, 1'b1, 1'b1);
        send(8'h11, 1);
        repeat (4) @(negedge clk);
        chk(tbe_flag == 1'b1, "R10 flag set after first pop", 32'(tbe_flag), 32'(1));
        tbe_clr = 1'b1;
        @(negedge clk);
        tbe_clr = 1'b0;
        send(8'h22, 1);
        chk(tx_empty == 1'b0, "R8 empty cleared by write", 32'(tx_empty), 32'(0));
        send(8'h33, 1);
        send(8'h44, 1);
        chk(tx_full == 1'b0, "R6 not full with three", 32'(tx_full), 32'(0));
        send(8'h55, 1);
        chk(tx_full == 1'b1, "R6 full with four", 32'(tx_full), 32'(1));
        chk(tx_empty == 1'b0, "R8 not empty when full", 32'(tx_empty), 32'(0));
        send(8'h66, 0);
        chk(tx_full == 1'b1, "R7 full after dropped write", 32'(tx_full), 32'(1));
        while (tx_empty !== 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(tx_active == 1'b1, "R9 active while last byte shifts", 32'(tx_active), 32'(1));
        chk(tbe_flag == 1'b1, "R10 flag set when queue drains", 32'(tbe_flag), 32'(1));
        wait_idle();
        chk(sb.size() == 0, "R6 all queued bytes sent in order", 32'(sb.size()), 32'(0));

        // 5 bits, no parity, one stop: 7 bits
        set_cfg(2'd3, 1'b1, 1'b0, 1'b1);
        send(8'hF3, 1);
        measure(7, "R3 R4 five-bit no-parity frame length");
        wait_idle();

        // 6 bits, even parity, two stops: 10 bits
        set_cfg(2'd2, 1'b0, 1'b0, 1'b0);
        send(8'h2D, 1);
        measure(10, "R5 six-bit two-stop frame length");
        wait_idle();

        // R11: change settings mid-frame; frame stays 8O1 = 11 bits
        set_cfg(2'd0, 1'b0, 1'b1, 1'b1);
        send(8'h96, 1);
        t = 0;
        repeat (40) begin
            @(negedge clk);
            t++;
        end
        char_len_code = 2'd3;
        no_parity     = 1'b1;
        while (tx_active === 1'b1) begin
            @(negedge clk);
            t++;
        end
        chk((t >= 11 * BIT_CLKS - 4) && (t <= 11 * BIT_CLKS + 4),
            "R11 frame keeps settings captured at start", 32'(t), 32'(11 * BIT_CLKS));
        repeat (4) @(negedge clk);
        send(8'h0B, 1);
        measure(7, "R11 new settings apply at next start");
        wait_idle();

        chk(tx_line == 1'b1, "R2 idle line high", 32'(tx_line), 32'(1));
        chk(tx_active == 1'b0, "R9 inactive when done", 32'(tx_active), 32'(0));
        chk(sb.size() == 0, "R7 no missing frame", 32'(sb.size()), 32'(0));
        finish_run();
    end

endmodule